// File: doc/BRIEF.md
# I2C Test-Unit Command Sequencer

This block is the command logic of an I2C target used to exercise bus masters under test. It sits behind a byte-level target front end that reports START, STOP, each received byte and each read request. For every received byte it returns an ACK or NACK decision in the same cycle. A host writes a frame of exactly four bytes: a command code, two configuration bytes and a delay count. Once the fourth byte is acknowledged, the unit goes busy and waits the requested number of 10 ms units. It then hands a request to a separate bus-master port, either to read a number of bytes from another address or to send an SMBus Host Notify message.

The request on the master port is a valid/ready stream of one descriptor. `mst_req_o` is the valid signal and `mst_ack_i` is the ready signal. Once raised, `mst_req_o` and every descriptor field hold steady until the cycle in which `mst_ack_i` is sampled high. The master then runs the transfer and pulses `mst_done_i` when it ends, whether the transfer completed or lost arbitration. Bytes the master collects during a read are not stored; the unit only counts them. A read of the unit at any time returns a fixed version byte.

Top module: `i2c_testunit_seq`

## Requirements
- R1: The received bytes fill positions 0 (command), 1 (low config), 2 (high config) and 3 (delay) in order. The position returns to 0 on every START and on every STOP. An action is started only by the acknowledged byte in position 3.
- R2: While `tgt_rd_req_i` is high, `tgt_rd_data_o` equals the VERSION parameter, at any point in a frame. Otherwise it is 0.
- R3: A command byte above 0x02 is NACKed and starts nothing. All further bytes are NACKed until the next START or STOP.
- R4: `busy_o` rises at the clock edge that accepts a frame and stays high until the action ends. Every byte received while `busy_o` is high is NACKed.
- R5: A frame cut short by STOP before its fourth byte is dropped. No action starts, and the next frame starts again at position 0.
- R6: `mst_req_o` rises exactly n×TICK_CYCLES+1 clock edges after the accepting edge, where n is the delay byte.
- R7: Command 0x01 (read) presents `mst_op_o`=0, `mst_addr_o` = low config byte bits 6:0 (bit 7 ignored) and `mst_count_o` = high config byte.
- R8: Command 0x02 (notify) presents `mst_op_o`=1, `mst_addr_o`=0x08 and `mst_count_o`=3. `mst_tx_o` carries bits 7:0 = OWN_ADDR shifted left by one, bits 15:8 = low config byte, and bits 23:16 = high config byte.
- R9: `mst_req_o` and its fields hold until `mst_ack_i` is seen. `busy_o` falls at the edge that samples `mst_done_i`.
- R10: Command 0x00 (no-op) raises no request. `busy_o` falls at the edge at which `mst_req_o` would otherwise have risen.
- R11: `rx_count_o` is cleared when a request is raised. It counts each cycle with `mst_rx_valid_i` high during a read transfer, from handshake to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tgt_start_i | input | 1 | START or repeated START addressed to the unit |
| tgt_stop_i | input | 1 | STOP seen on the bus |
| tgt_wr_valid_i | input | 1 | A written byte is present this cycle |
| tgt_wr_data_i | input | 8 | Written byte |
| tgt_ack_o | output | 1 | ACK (1) or NACK (0) for the present byte |
| tgt_rd_req_i | input | 1 | Host reads a byte |
| tgt_rd_data_o | output | 8 | Byte returned to a read |
| busy_o | output | 1 | A frame is accepted and its action is not finished |
| mst_req_o | output | 1 | Master descriptor valid |
| mst_ack_i | input | 1 | Master descriptor ready |
| mst_op_o | output | 1 | 0 read, 1 notify |
| mst_addr_o | output | 7 | Target bus address |
| mst_count_o | output | 8 | Byte count |
| mst_tx_o | output | 24 | Notify payload, first byte in bits 7:0 |
| mst_done_i | input | 1 | Master transfer finished |
| mst_rx_valid_i | input | 1 | Master received one byte |
| rx_count_o | output | 8 | Bytes received in the current read |

## Verification
The bench builds the block with TICK_CYCLES=3, OWN_ADDR=0x30 and VERSION=0xA5. A short tick lets delays of zero, one and two units be timed edge by edge within a few cycles, including the zero-delay case in which the request follows the accepting edge by a single edge. The non-zero own address and the distinctive version byte make the shifted notify byte and the read data easy to tell apart from reset values.

// File: rtl/tu_pkg.sv
package tu_pkg;
  localparam logic [7:0] CMD_NOOP   = 8'h00;
  localparam logic [7:0] CMD_READ   = 8'h01;
  localparam logic [7:0] CMD_NOTIFY = 8'h02;
  localparam logic [6:0] HOST_ADDR  = 7'h08;
  localparam logic [7:0] NOTIFY_LEN = 8'd3;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] cfg_lo;
    logic [7:0] cfg_hi;
    logic [7:0] wait_n;
  } tu_frame_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_MASTER} tu_state_e;
endpackage

// File: rtl/tu_frame_rx.sv
module tu_frame_rx
  import tu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       busy_i,
  output logic       ack_o,
  output logic       accept_o,
  output tu_frame_t  frame_o
);
  logic [2:0] pos_q;
  logic       rej_q;
  logic [7:0] b0_q, b1_q, b2_q;
  logic       cmd_ok;

  assign cmd_ok   = (wr_data_i <= CMD_NOTIFY);
  assign ack_o    = wr_valid_i && !busy_i && !rej_q && (pos_q < 3'd4) &&
                    ((pos_q != 3'd0) || cmd_ok);
  assign accept_o = ack_o && (pos_q == 3'd3);
  assign frame_o  = '{cmd: b0_q, cfg_lo: b1_q, cfg_hi: b2_q, wait_n: wr_data_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 3'd0;
      rej_q <= 1'b0;
      b0_q  <= 8'h00;
      b1_q  <= 8'h00;
      b2_q  <= 8'h00;
    end else if (start_i || stop_i) begin
      pos_q <= 3'd0;
      rej_q <= 1'b0;
    end else if (wr_valid_i) begin
      if (ack_o) begin
        pos_q <= pos_q + 3'd1;
        case (pos_q)
          3'd0:    b0_q <= wr_data_i;
          3'd1:    b1_q <= wr_data_i;
          3'd2:    b2_q <= wr_data_i;
          default: ;
        endcase
      end else begin
        rej_q <= 1'b1;
      end
    end
  end

  // R3: once a byte was refused, nothing more is taken until START/STOP
  assert_reject_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_q && !start_i && !stop_i) |=> rej_q);
endmodule

// File: rtl/tu_delay.sv
module tu_delay #(
  parameter int TICK_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] count_i,
  input  logic       run_i,
  output logic       done_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;
  logic [7:0]    rem_q;
  logic          tick;

  assign tick   = run_i && (pre_q == PRE_MAX);
  assign done_o = (rem_q == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rem_q <= 8'd0;
    end else if (load_i) begin
      pre_q <= '0;
      rem_q <= count_i;
    end else if (run_i) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && rem_q != 8'd0) rem_q <= rem_q - 8'd1;
    end
  end

  // R6: the remaining unit count never grows except on a load
  assert_rem_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> rem_q <= $past(rem_q));
endmodule

// File: rtl/tu_master_req.sv
module tu_master_req
  import tu_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  tu_frame_t   frame_i,
  output logic        req_o,
  input  logic        ack_i,
  output logic        op_o,
  output logic [6:0]  addr_o,
  output logic [7:0]  count_o,
  output logic [23:0] tx_o,
  input  logic        done_i,
  input  logic        rx_valid_i,
  output logic [7:0]  rx_count_o,
  output logic        fin_o
);
  logic waiting_q;

  assign fin_o = waiting_q && done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o      <= 1'b0;
      waiting_q  <= 1'b0;
      op_o       <= 1'b0;
      addr_o     <= 7'h00;
      count_o    <= 8'h00;
      tx_o       <= 24'h0;
      rx_count_o <= 8'h00;
    end else if (launch_i) begin
      req_o      <= 1'b1;
      rx_count_o <= 8'h00;
      if (frame_i.cmd == CMD_NOTIFY) begin
        op_o    <= 1'b1;
        addr_o  <= HOST_ADDR;
        count_o <= NOTIFY_LEN;
        tx_o    <= {frame_i.cfg_hi, frame_i.cfg_lo, OWN_ADDR, 1'b0};
      end else begin
        op_o    <= 1'b0;
        addr_o  <= frame_i.cfg_lo[6:0];
        count_o <= frame_i.cfg_hi;
        tx_o    <= 24'h0;
      end
    end else begin
      if (req_o && ack_i) begin
        req_o     <= 1'b0;
        waiting_q <= 1'b1;
      end
      if (waiting_q && rx_valid_i && !op_o) rx_count_o <= rx_count_o + 8'd1;
      if (fin_o) waiting_q <= 1'b0;
    end
  end

  // R9: descriptor held steady until accepted
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(count_o) &&
                           $stable(op_o) && $stable(tx_o)));
  // R8: notify always goes to the host address with three bytes
  assert_notify_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && op_o) |-> (addr_o == HOST_ADDR && count_o == NOTIFY_LEN));
  // R11: the counter only moves during a read transfer or on a new request
  assert_rx_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting_q && !launch_i) |=> $stable(rx_count_o));
endmodule

// File: rtl/i2c_testunit_seq.sv
module i2c_testunit_seq
  import tu_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h30,
  parameter logic [7:0] VERSION     = 8'h01,
  parameter int         TICK_CYCLES = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tgt_start_i,
  input  logic        tgt_stop_i,
  input  logic        tgt_wr_valid_i,
  input  logic [7:0]  tgt_wr_data_i,
  output logic        tgt_ack_o,
  input  logic        tgt_rd_req_i,
  output logic [7:0]  tgt_rd_data_o,
  output logic        busy_o,
  output logic        mst_req_o,
  input  logic        mst_ack_i,
  output logic        mst_op_o,
  output logic [6:0]  mst_addr_o,
  output logic [7:0]  mst_count_o,
  output logic [23:0] mst_tx_o,
  input  logic        mst_done_i,
  input  logic        mst_rx_valid_i,
  output logic [7:0]  rx_count_o
);
  tu_state_e state_q;
  tu_frame_t frame_rx, frame_q;
  logic      accept, dly_done, launch, fin;

  assign busy_o        = (state_q != ST_IDLE);
  assign tgt_rd_data_o = tgt_rd_req_i ? VERSION : 8'h00;
  assign launch        = (state_q == ST_DELAY) && dly_done && (frame_q.cmd != CMD_NOOP);

  tu_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .start_i(tgt_start_i), .stop_i(tgt_stop_i),
    .wr_valid_i(tgt_wr_valid_i), .wr_data_i(tgt_wr_data_i), .busy_i(busy_o),
    .ack_o(tgt_ack_o), .accept_o(accept), .frame_o(frame_rx)
  );

  tu_delay #(.TICK_CYCLES(TICK_CYCLES)) u_dly (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .count_i(frame_rx.wait_n),
    .run_i(state_q == ST_DELAY), .done_o(dly_done)
  );

  tu_master_req #(.OWN_ADDR(OWN_ADDR)) u_mst (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .frame_i(frame_q),
    .req_o(mst_req_o), .ack_i(mst_ack_i), .op_o(mst_op_o), .addr_o(mst_addr_o),
    .count_o(mst_count_o), .tx_o(mst_tx_o), .done_i(mst_done_i),
    .rx_valid_i(mst_rx_valid_i), .rx_count_o(rx_count_o), .fin_o(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_DELAY;
          frame_q <= frame_rx;
        end
        ST_DELAY: if (dly_done) state_q <= (frame_q.cmd == CMD_NOOP) ? ST_IDLE : ST_MASTER;
        ST_MASTER: if (fin) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: busy refuses every byte
  assert_busy_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tgt_wr_valid_i) |-> !tgt_ack_o);
  // R4: a request only exists inside a busy period
  assert_req_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mst_req_o |-> busy_o);
  // R10: a no-op never reaches the master port
  assert_noop_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mst_req_o |-> (frame_q.cmd == CMD_READ || frame_q.cmd == CMD_NOTIFY));
endmodule

// File: tb/i2c_testunit_seq_test.sv
module i2c_testunit_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 3;
  localparam logic [6:0] OWN = 7'h30;
  localparam logic [7:0] VER = 8'hA5;

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, wv = 0, rd = 0, mack = 0, mdone = 0, mrx = 0;
  logic [7:0] wd = 0;
  logic ack, busy, req, op;
  logic [7:0] rdd, cnt, rxc;
  logic [6:0] addr;
  logic [23:0] tx;

  int checks = 0, fails = 0, cyc = 0;

  // reference model state
  int m_st = 0, m_dly = 0, m_ptr = 0, m_rxc = 0;
  bit m_rej = 0, m_op = 0;
  int m_cmd = 0, m_lo = 0, m_hi = 0, m_addr = 0, m_cnt = 0, m_tx = 0;
  int f_cmd = 0, f_lo = 0, f_hi = 0;

  i2c_testunit_seq #(.OWN_ADDR(OWN), .VERSION(VER), .TICK_CYCLES(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .tgt_start_i(start), .tgt_stop_i(stop),
    .tgt_wr_valid_i(wv), .tgt_wr_data_i(wd), .tgt_ack_o(ack),
    .tgt_rd_req_i(rd), .tgt_rd_data_o(rdd), .busy_o(busy),
    .mst_req_o(req), .mst_ack_i(mack), .mst_op_o(op), .mst_addr_o(addr),
    .mst_count_o(cnt), .mst_tx_o(tx), .mst_done_i(mdone),
    .mst_rx_valid_i(mrx), .rx_count_o(rxc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_ack();
    return wv && m_st == 0 && !m_rej && m_ptr < 4 && (m_ptr != 0 || wd <= 8'h02);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, stepped on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_rej = 0; m_rxc = 0; m_op = 0;
      m_addr = 0; m_cnt = 0; m_tx = 0;
    end else begin
      bit a;
      a = exp_ack();
      case (m_st)
        1: if (m_dly == 0) begin
             if (m_cmd == 0) m_st = 0;
             else begin
               m_st = 2; m_rxc = 0;
               if (m_cmd == 2) begin
                 m_op = 1; m_addr = 8; m_cnt = 3;
                 m_tx = (m_hi << 16) | (m_lo << 8) | (OWN << 1);
               end else begin
                 m_op = 0; m_addr = m_lo & 8'h7f; m_cnt = m_hi; m_tx = 0;
               end
             end
           end else m_dly--;
        2: if (mack) m_st = 3;
        3: begin
             if (mrx && !m_op) m_rxc = (m_rxc + 1) % 256;
             if (mdone) m_st = 0;
           end
        default: ;
      endcase
      if (start || stop) begin m_ptr = 0; m_rej = 0; end
      else if (wv) begin
        if (a) begin
          case (m_ptr)
            0: f_cmd = wd;
            1: f_lo = wd;
            2: f_hi = wd;
            default: begin
              m_cmd = f_cmd; m_lo = f_lo; m_hi = f_hi;
              m_st = 1; m_dly = wd * TICK;
            end
          endcase
          m_ptr++;
        end else m_rej = 1;
      end
    end
  end

  // every-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 R10 busy", busy, m_st != 0);
      check("R6 R9 req", req, m_st == 2);
      check("R11 rx_count", rxc, m_rxc);
      if (m_st == 2) begin
        check(m_op ? "R8 op" : "R7 op", op, m_op);
        check(m_op ? "R8 addr" : "R7 addr", addr, m_addr);
        check(m_op ? "R8 count" : "R7 count", cnt, m_cnt);
        if (m_op) check("R8 payload", tx, m_tx);
      end
    end
  end

  task automatic pulse_start(); @(negedge clk); start = 1; @(posedge clk); #1 start = 0; endtask
  task automatic pulse_stop();  @(negedge clk); stop = 1;  @(posedge clk); #1 stop = 0;  endtask

  task automatic put(string tag, logic [7:0] d);
    @(negedge clk); wv = 1; wd = d; #1;
    check(tag, ack, exp_ack());
    @(posedge clk); #1 wv = 0;
  endtask

  task automatic rd_check(string tag);
    @(negedge clk); rd = 1; #1;
    check(tag, rdd, VER);
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic frame(logic [7:0] c, logic [7:0] l, logic [7:0] h, logic [7:0] n);
    pulse_start();
    put("R1 R3 cmd byte", c); put("R1 cfg lo", l); put("R1 cfg hi", h); put("R1 delay byte", n);
    pulse_stop();
  endtask

  task automatic serve(int nrx, int stall);
    while (!req) @(negedge clk);
    repeat (stall) @(negedge clk);
    mack = 1; @(posedge clk); #1 mack = 0;
    for (int i = 0; i < nrx; i++) begin
      @(negedge clk); mrx = 1; @(posedge clk); #1 mrx = 0;
    end
    @(negedge clk); mdone = 1; @(posedge clk); #1 mdone = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R4 reset busy", busy, 0);
    check("R9 reset req", req, 0);
    check("R11 reset rx_count", rxc, 0);
    rst_n = 1;
    @(negedge clk);
    rd_check("R2 version idle");

    // R7: read with bit 7 of the address set, delay 2 units, NACK while busy (R4)
    frame(8'h01, 8'hD0, 8'h05, 8'h02);
    rd_check("R2 version busy");
    pulse_start(); put("R4 nack while busy", 8'h01); pulse_stop();
    serve(5, 2);
    @(negedge clk);
    check("R11 bytes counted", rxc, 5);
    wait_idle();

    // R3: unknown command, then sticky NACK
    pulse_start(); put("R3 bad cmd", 8'h07); put("R3 after bad", 8'h00); pulse_stop();
    repeat (2) @(negedge clk);
    check("R3 no action", busy, 0);

    // R5: short frame dropped, the next frame restarts at position 0
    pulse_start(); put("R5 cmd", 8'h01); rd_check("R2 version mid"); put("R5 lo", 8'h11); put("R5 hi", 8'h22);
    pulse_stop();
    repeat (2) @(negedge clk);
    check("R5 short frame ignored", busy, 0);

    // R8: notify with zero delay
    frame(8'h02, 8'h42, 8'h64, 8'h00);
    serve(0, 1);
    wait_idle();

    // R10: no-op with one unit of delay
    frame(8'h00, 8'h12, 8'h34, 8'h01);
    wait_idle();
    check("R10 no request", req, 0);

    // R1: restart mid-frame resets the position
    pulse_start(); put("R1 partial", 8'h02); put("R1 partial lo", 8'h01);
    frame(8'h01, 8'h2A, 8'h03, 8'h00);
    serve(3, 0);
    wait_idle();
    check("R11 second read count", rxc, 3);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule